// File: doc/BRIEF.md
# Five-Mode Logarithmic Barrel Shifter

This block moves an N-bit word by any distance from zero to N-1 in a single pass. N must be a power of two and defaults to 8. A three-bit mode input picks one of five operations: two logical shifts, a sign-preserving right shift, and two rotations. The core is a chain of log2(N) two-way multiplexer stages. Stage k moves the word by 2^k places when bit k of the distance is set, and passes it through otherwise.

Only one left-moving core exists. For a right-moving mode, the word is mirrored (bit i swapped with bit N-1-i) before the core and mirrored again after it. A left move on the mirrored word is then a right move on the original. For the sign-preserving mode, each stage fills the vacated places with the original top bit.

The result is captured in one output register, which has a synchronous active-high reset. A parent datapath drives word, distance and mode together and takes the result one clock later.

Top module: `barrel_shift_unit`

## Requirements
- R1: Mode code 3'b000 gives a logical left move. `dout` equals `din` moved toward the MSB by `amt` places, and the freed low places are 0.
- R2: Mode code 3'b001 gives a logical right move. `dout` equals `din` moved toward the LSB by `amt` places, and the freed high places are 0.
- R3: Mode code 3'b010 gives an arithmetic right move. The freed high places all hold bit N-1 of the original `din`.
- R4: Mode code 3'b011 gives a left rotation. The bits pushed out past the MSB come back in at the LSB, in order.
- R5: Mode code 3'b100 gives a right rotation. The bits pushed out past the LSB come back in at the MSB, in order.
- R6: When `amt` is 0, `dout` equals `din` in every mode.
- R7: Mode codes 3'b101, 3'b110 and 3'b111 return `din` unchanged, whatever the value of `amt`.
- R8: While `rst` is high at a rising edge, `dout` becomes 0 at that edge.
- R9: The result for the inputs present at a rising edge appears on `dout` right after that edge and holds until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | W | Word to be moved |
| amt | input | log2(W) | Distance in bit places |
| mode | input | 3 | Operation select; codes are listed in R1 to R7 |
| dout | output | W | Registered result |

## Verification
Every result has a latency of exactly one rising edge. The inputs sampled at an edge produce `dout` just after that edge, and reset takes effect at that same edge. The bench drives `din`, `amt` and `mode` on a falling edge, lets one rising edge capture them, and reads `dout` on the next falling edge, midway between captures. The in-design properties apply the same one-edge offset through `$past`.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam logic [2:0] OP_SLL = 3'b000;
  localparam logic [2:0] OP_SRL = 3'b001;
  localparam logic [2:0] OP_SRA = 3'b010;
  localparam logic [2:0] OP_ROL = 3'b011;
  localparam logic [2:0] OP_ROR = 3'b100;
endpackage

// File: rtl/bshift_mirror.sv
module bshift_mirror #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] y
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y[i] = a[W-1-i];
  end
endmodule

// File: rtl/bshift_stage.sv
module bshift_stage #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic [W-1:0] d,
  input  logic         en,
  input  logic         rot,
  input  logic         fill,
  output logic [W-1:0] q
);
  logic [W-1:0] wrapped;
  logic [W-1:0] filled;

  assign wrapped = {d[W-1-D:0], d[W-1:W-D]};
  assign filled  = {d[W-1-D:0], {D{fill}}};

  always_comb begin
    if (!en)      q = d;
    else if (rot) q = wrapped;
    else          q = filled;
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  d,
  input  logic [AW-1:0] amt,
  input  logic          rot,
  input  logic          fill,
  output logic [W-1:0]  q
);
  logic [W-1:0] lv [0:AW];

  assign lv[0] = d;

  for (genvar k = 0; k < AW; k++) begin : g_stage
    bshift_stage #(.W(W), .D(1 << k)) u_st (
      .d   (lv[k]),
      .en  (amt[k]),
      .rot (rot),
      .fill(fill),
      .q   (lv[k+1])
    );
  end

  assign q = lv[AW];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import bshift_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [2:0]    mode,
  output logic [W-1:0]  dout
);
  logic          is_right;
  logic          is_rot;
  logic          is_known;
  logic          fill_bit;
  logic [W-1:0]  din_rev;
  logic [W-1:0]  core_in;
  logic [W-1:0]  core_out;
  logic [W-1:0]  core_rev;
  logic [AW-1:0] eff_amt;
  logic [W-1:0]  nxt;

  assign is_right = (mode == OP_SRL) || (mode == OP_SRA) || (mode == OP_ROR);
  assign is_rot   = (mode == OP_ROL) || (mode == OP_ROR);
  assign is_known = (mode <= OP_ROR);
  assign fill_bit = (mode == OP_SRA) ? din[W-1] : 1'b0;
  assign eff_amt  = is_known ? amt : '0;

  bshift_mirror #(.W(W)) u_mir_in  (.a(din),      .y(din_rev));
  assign core_in = is_right ? din_rev : din;

  bshift_core #(.W(W), .AW(AW)) u_core (
    .d   (core_in),
    .amt (eff_amt),
    .rot (is_rot),
    .fill(fill_bit),
    .q   (core_out)
  );

  bshift_mirror #(.W(W)) u_mir_out (.a(core_out), .y(core_rev));
  assign nxt = is_right ? core_rev : core_out;

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= nxt;
  end

  p_reset_r8: assert property (@(posedge clk) $past(rst) |-> dout == '0);

  p_zero_amt_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(amt) == '0) |-> dout == $past(din));

  p_other_code_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) > OP_ROR) |-> dout == $past(din));

  p_sll_lsb_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == OP_SLL && $past(amt) != '0) |-> dout[0] == 1'b0);

  p_srl_msb_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == OP_SRL && $past(amt) != '0) |-> dout[W-1] == 1'b0);

  p_sra_sign_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == OP_SRA) |-> dout[W-1] == $past(din[W-1]));

  p_rot_ones_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(mode) == OP_ROL || $past(mode) == OP_ROR))
      |-> $countones(dout) == $countones($past(din)));
endmodule

// File: tb/sim_barrel_shift_unit.sv
module sim_barrel_shift_unit;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic [W-1:0]  din;
  logic [AW-1:0] amt;
  logic [2:0]    mode;
  logic [W-1:0]  dout;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  barrel_shift_unit #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .din(din), .amt(amt), .mode(mode), .dout(dout)
  );

  function automatic logic [W-1:0] model(logic [2:0] m, logic [W-1:0] d, int a);
    logic [2*W-1:0] t;
    case (m)
      3'b000: return d << a;
      3'b001: return d >> a;
      3'b010: return W'($signed(d) >>> a);
      3'b011: begin t = {d, d} << a; return t[2*W-1:W]; end
      3'b100: begin t = {d, d} >> a; return t[W-1:0]; end
      default: return d;
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s: mode=%b amt=%0d din=%h got %h expected %h",
               req, mode, amt, din, dout, exp);
    end
  endtask

  task automatic apply_and_check(string req, logic [2:0] m, logic [W-1:0] d, int a);
    @(negedge clk);
    mode = m; din = d; amt = AW'(a);
    @(negedge clk);
    check(req, model(m, d, a));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1; mode = 3'b011; din = 8'hFF; amt = 3'd2;
    @(negedge clk);
    check("R8", 8'h00);
    rst = 1'b0;
  endtask

  task automatic t_mode(string req, logic [2:0] m);
    logic [W-1:0] pats [4] = '{8'h96, 8'h01, 8'h80, 8'hC3};
    foreach (pats[p])
      for (int a = 0; a < W; a++) apply_and_check(req, m, pats[p], a);
  endtask

  task automatic t_sra_signs();
    apply_and_check("R3", 3'b010, 8'h81, 7);
    apply_and_check("R3", 3'b010, 8'h7F, 7);
    apply_and_check("R3", 3'b010, 8'hB4, 3);
  endtask

  task automatic t_zero_amt();
    for (int m = 0; m < 8; m++) apply_and_check("R6", 3'(m), 8'h5A, 0);
  endtask

  task automatic t_other_codes();
    for (int m = 5; m < 8; m++)
      for (int a = 0; a < W; a++) apply_and_check("R7", 3'(m), 8'h3C, a);
  endtask

  task automatic t_latency();
    @(negedge clk);
    mode = 3'b000; din = 8'h01; amt = 3'd4;
    @(negedge clk);
    check("R9", 8'h10);
    mode = 3'b001; din = 8'h80; amt = 3'd1;
    @(posedge clk);
    #1;
    check("R9", 8'h40);
    @(negedge clk);
    check("R9", 8'h40);
  endtask

  initial begin
    rst = 1'b1; din = '0; amt = '0; mode = '0;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode("R1", 3'b000);
    t_mode("R2", 3'b001);
    t_mode("R3", 3'b010);
    t_mode("R4", 3'b011);
    t_mode("R5", 3'b100);
    t_sra_signs();
    t_zero_amt();
    t_other_codes();
    t_latency();
    t_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule